// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

This block is a memory-mapped down-counter. Software reaches it through a small synchronous register port with word accesses inside a 32-byte window. The counter is 32 bits wide. While the timer is enabled, an 8-bit prescaler stretches each decrement over P+1 clock cycles.

When the count runs out, a sticky status flag is raised. The flag drives a level interrupt output directly. The counter then either refills from a stored reload value and keeps running, or drops to zero and stops. Software clears the flag by writing a one to it.

A zero count is inert: it never expires and never raises the flag. The one exception is the moment the timer is switched on with auto-reload selected. At that moment a zero count is first refilled from the reload value.

Top module: `cdt_timer`

## Requirements
- R1: After reset the reload value, count, control and status all read 0 and `irq_o` is 0.
- R2: Registers are selected by word-aligned byte offset: 0x00 reload value, 0x04 count, 0x08 control, 0x0C status. Control bit 0 is enable, bit 1 is auto-reload, bits 15:8 are the prescale P, and all other control bits read 0. Any other offset (0x10 to 0x1C, or any offset with address bits 1:0 nonzero) reads 0, and a write to it changes no register.
- R3: While enabled with a nonzero count, the count drops by one every P+1 cycles, with the first decrement P+1 cycles after enabling or after a count write. While disabled, the count and the prescaler phase hold.
- R4: When a decrement would take the count from 1 to 0, the status flag (read as bit 0 at 0x0C) becomes 1, and `irq_o` equals that flag.
- R5: On expiry with auto-reload set, the count takes the reload value and counting continues.
- R6: On expiry with auto-reload clear, the count becomes 0 and stays 0. The enable bit stays set.
- R7: A write to 0x00 sets both the reload value and the count. A write to 0x04 sets only the count. Either write restarts the prescaler phase, and it overrides a decrement that would fall in the same cycle.
- R8: A count of 0 never expires and never sets the status flag.
- R9: A control write that takes enable from 0 to 1 with auto-reload set, while the count is 0, loads the count from the reload value. With auto-reload clear, the count stays 0.
- R10: Reading 0x04 returns 0 while the timer is disabled. Otherwise it returns the current count.
- R11: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R12: If an expiry and a clear of the flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as a read strobe |
| irq_o | output | 1 | Level interrupt, equal to the status flag |

## Verification
The counting path is exercised with prescale 0 and prescale 3. This separates a decrement on every cycle from a decrement every fourth cycle, and the count is checked on both sides of each expiry edge. The end of a count is driven in three ways:
- one-shot mode, where the count must stop at zero;
- auto-reload mode, where the count must refill and expire again;
- a count of zero, which must stay silent.

Further patterns cover the remaining cases:
- a count write landing exactly on a pending decrement;
- a flag clear landing exactly on an expiry;
- enabling with a zero count, with and without auto-reload.

Each of these tells apart which of two simultaneous events wins.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // Register selector taken from the word index of the byte offset.
  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STAT   = 2'd3
  } reg_sel_e;

  // Control field positions.
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_AUTO_BIT = 1;
  localparam int unsigned CTRL_PRE_LSB  = 8;

  // Status flag position.
  localparam int unsigned STAT_FLAG_BIT = 0;

  // Number of mapped word registers.
  localparam int unsigned NUM_REGS = 4;

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] phase_q, phase_d;
  logic             phase_ce;
  logic             at_limit;

  // ">=" so that lowering P mid-count cannot force a long wrap.
  assign at_limit = (phase_q >= limit_i);
  assign tick_o   = enable_i && at_limit;

  always_comb begin
    phase_d  = phase_q;
    phase_ce = 1'b0;
    if (restart_i) begin
      phase_d  = '0;
      phase_ce = 1'b1;
    end else if (enable_i) begin
      phase_d  = at_limit ? '0 : phase_q + PRE_W'(1);
      phase_ce = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (phase_ce) begin
      phase_q <= phase_d;
    end
  end

  AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (phase_q == '0)); // R7

  AST_PHASE_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !restart_i) |=> $stable(phase_q)); // R3

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              auto_i,
  input  logic [DATA_W-1:0] reload_val_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fill_arm_i,
  output logic [DATA_W-1:0] count_o,
  output logic              expire_o
);

  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              cnt_ce;
  logic              is_zero;
  logic              step;

  assign is_zero  = (cnt_q == '0);
  assign step     = enable_i && tick_i && !is_zero && !wr_i;
  assign expire_o = step && (cnt_q == DATA_W'(1));
  assign count_o  = cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (wr_i) begin
      cnt_d  = wr_data_i;
      cnt_ce = 1'b1;
    end else if (fill_arm_i && is_zero) begin
      cnt_d  = reload_val_i;
      cnt_ce = 1'b1;
    end else if (step) begin
      cnt_ce = 1'b1;
      if (cnt_q == DATA_W'(1)) begin
        cnt_d = auto_i ? reload_val_i : '0;
      end else begin
        cnt_d = cnt_q - DATA_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && tick_i && !wr_i && (cnt_q > DATA_W'(1))) |=>
      (cnt_q == $past(cnt_q) - DATA_W'(1))); // R3

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !wr_i && !fill_arm_i) |=> $stable(cnt_q)); // R3

  AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && auto_i) |=> (cnt_q == $past(reload_val_i))); // R5

  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !auto_i) |=> (cnt_q == '0)); // R6

  AST_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wr_data_i))); // R7

  AST_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_zero && !wr_i && !fill_arm_i) |=> (cnt_q == '0)); // R8

  AST_ZERO_NO_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_zero |-> !expire_o); // R8

  AST_FILL_ON_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_arm_i && is_zero && !wr_i) |=> (cnt_q == $past(reload_val_i))); // R9

endmodule

// File: rtl/cdt_regif.sv
module cdt_regif
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] count_i,
  input  logic              expire_i,
  output logic              reload_wr_o,
  output logic              count_wr_o,
  output logic              fill_arm_o,
  output logic              en_rise_o,
  output logic              enable_o,
  output logic              auto_o,
  output logic [PRE_W-1:0]  prescale_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              status_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              mapped;
  reg_sel_e          rsel;
  logic              wr_hit, rd_hit;
  logic              ctrl_wr, stat_wr, clr_req;

  logic [DATA_W-1:0] reload_q, reload_d;
  logic              en_q, en_d;
  logic              auto_q, auto_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic              stat_q, stat_d;
  logic              reload_ce, ctrl_ce, stat_ce;

  // Address decode
  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign mapped  = aligned && (idx < IDX_W'(NUM_REGS));
  assign rsel    = reg_sel_e'(idx[1:0]);
  assign wr_hit  = sel_i && we_i && mapped;
  assign rd_hit  = sel_i && !we_i && mapped;

  assign reload_wr_o = wr_hit && (rsel == SEL_RELOAD);
  assign count_wr_o  = wr_hit && (rsel == SEL_COUNT);
  assign ctrl_wr     = wr_hit && (rsel == SEL_CTRL);
  assign stat_wr     = wr_hit && (rsel == SEL_STAT);
  assign clr_req     = stat_wr && wdata_i[STAT_FLAG_BIT];

  assign en_rise_o  = ctrl_wr && wdata_i[CTRL_EN_BIT] && !en_q;
  assign fill_arm_o = en_rise_o && wdata_i[CTRL_AUTO_BIT];

  // Next-state logic
  always_comb begin
    reload_d  = reload_q;
    reload_ce = reload_wr_o;
    if (reload_wr_o) begin
      reload_d = wdata_i;
    end

    en_d    = en_q;
    auto_d  = auto_q;
    pre_d   = pre_q;
    ctrl_ce = ctrl_wr;
    if (ctrl_wr) begin
      en_d   = wdata_i[CTRL_EN_BIT];
      auto_d = wdata_i[CTRL_AUTO_BIT];
      pre_d  = wdata_i[CTRL_PRE_LSB +: PRE_W];
    end

    // Setting the flag has priority over clearing it.
    stat_d  = stat_q;
    stat_ce = expire_i || clr_req;
    if (expire_i) begin
      stat_d = 1'b1;
    end else if (clr_req) begin
      stat_d = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
    end else if (reload_ce) begin
      reload_q <= reload_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      pre_q  <= '0;
    end else if (ctrl_ce) begin
      en_q   <= en_d;
      auto_q <= auto_d;
      pre_q  <= pre_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  // Read mux
  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      unique case (rsel)
        SEL_RELOAD: rdata_o = reload_q;
        SEL_COUNT:  rdata_o = en_q ? count_i : '0;
        SEL_CTRL: begin
          rdata_o[CTRL_PRE_LSB +: PRE_W] = pre_q;
          rdata_o[CTRL_AUTO_BIT]         = auto_q;
          rdata_o[CTRL_EN_BIT]           = en_q;
        end
        SEL_STAT:   rdata_o[STAT_FLAG_BIT] = stat_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign enable_o   = en_q;
  assign auto_o     = auto_q;
  assign prescale_o = pre_q;
  assign reload_o   = reload_q;
  assign status_o   = stat_q;

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && !mapped) |=> ($stable(reload_q) && $stable(en_q) && $stable(auto_q) && $stable(pre_q))); // R2

  AST_FLAG_ON_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> stat_q); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !expire_i) |=> !stat_q); // R11

  AST_W0_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && !wdata_i[STAT_FLAG_BIT] && stat_q) |=> stat_q); // R11

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && clr_req) |=> stat_q); // R12

  AST_COUNT_READ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && (rsel == SEL_COUNT) && !en_q) |-> (rdata_o == '0)); // R10

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              reload_wr, count_wr, fill_arm, en_rise;
  logic              enable, auto_rl, status, tick, expire;
  logic [PRE_W-1:0]  prescale;
  logic [DATA_W-1:0] reload_val, count_val;

  cdt_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W)
  ) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .sel_i       (bus_sel_i),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .count_i     (count_val),
    .expire_i    (expire),
    .reload_wr_o (reload_wr),
    .count_wr_o  (count_wr),
    .fill_arm_o  (fill_arm),
    .en_rise_o   (en_rise),
    .enable_o    (enable),
    .auto_o      (auto_rl),
    .prescale_o  (prescale),
    .reload_o    (reload_val),
    .status_o    (status)
  );

  cdt_prescaler #(
    .PRE_W (PRE_W)
  ) u_prescaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .enable_i  (enable),
    .restart_i (reload_wr || count_wr || en_rise),
    .limit_i   (prescale),
    .tick_o    (tick)
  );

  cdt_counter #(
    .DATA_W (DATA_W)
  ) u_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_q),
    .enable_i     (enable),
    .tick_i       (tick),
    .auto_i       (auto_rl),
    .reload_val_i (reload_val),
    .wr_i         (reload_wr || count_wr),
    .wr_data_i    (bus_wdata_i),
    .fill_arm_i   (fill_arm),
    .count_o      (count_val),
    .expire_o     (expire)
  );

  assign irq_o = status;

  AST_IRQ_IDLE_IN_RESET: assert property (@(posedge clk_i)
    !rst_sync_q |=> (!irq_o || rst_sync_q)); // R1

endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        sel;
  logic        we;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  cdt_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_sel_i   (sel),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [4:0] A_RLD = 5'h00, A_CNT = 5'h04, A_CTL = 5'h08, A_STA = 5'h0C;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // One write, committed at the next rising edge; returns 1 ns after it.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    sel = 1'b0; we = 1'b0;
  endtask

  // Combinational read inside the current cycle, no edge consumed.
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata;
    sel = 1'b0;
    #1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_RLD, v); chk("R1", v, 0, "reload after reset");
    rd(A_CNT, v); chk("R1", v, 0, "count after reset");
    rd(A_CTL, v); chk("R1", v, 0, "control after reset");
    rd(A_STA, v); chk("R1", v, 0, "status after reset");
    chk("R1", {31'b0, irq}, 0, "irq after reset");
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(A_CTL, 32'hFFFF_AB02);
    rd(A_CTL, v); chk("R2", v, 32'h0000_AB02, "control field readback");
    wr(A_RLD, 32'h0000_1234);
    wr(5'h10, 32'h5555_5555);
    wr(5'h01, 32'h7777_7777);
    rd(A_RLD, v); chk("R2", v, 32'h0000_1234, "reload untouched by unmapped write");
    rd(A_CTL, v); chk("R2", v, 32'h0000_AB02, "control untouched by unmapped write");
    rd(5'h14, v); chk("R2", v, 0, "unmapped offset reads zero");
    rd(5'h09, v); chk("R2", v, 0, "misaligned offset reads zero");
    wr(A_CTL, 32'h0);
    wr(A_RLD, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(A_CNT, 32'd5);
    rd(A_CNT, v); chk("R10", v, 0, "count read while disabled");
    rd(A_RLD, v); chk("R7", v, 0, "count write leaves reload");
    wr(A_CTL, 32'h0000_0001);
    edges(4);
    rd(A_CNT, v); chk("R3", v, 1, "count after 4 cycles at P=0");
    rd(A_STA, v); chk("R4", v, 0, "flag before expiry");
    edges(1);
    rd(A_STA, v); chk("R4", v, 1, "flag at expiry");
    chk("R4", {31'b0, irq}, 1, "irq follows flag");
    rd(A_CNT, v); chk("R6", v, 0, "one-shot count at zero");
    rd(A_CTL, v); chk("R6", v, 32'h1, "enable kept after one-shot");
    edges(3);
    rd(A_CNT, v); chk("R6", v, 0, "one-shot count stays zero");
    wr(A_STA, 32'h0);
    rd(A_STA, v); chk("R11", v, 1, "writing 0 keeps flag");
    wr(A_STA, 32'h1);
    rd(A_STA, v); chk("R11", v, 0, "writing 1 clears flag");
    chk("R11", {31'b0, irq}, 0, "irq low after clear");
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    wr(A_RLD, 32'd3);
    rd(A_RLD, v); chk("R7", v, 3, "reload write stored");
    wr(A_CTL, 32'h0000_0301);
    rd(A_CNT, v); chk("R7", v, 3, "reload write copied to count");
    edges(3);
    rd(A_CNT, v); chk("R3", v, 3, "no decrement before P+1 cycles");
    edges(1);
    rd(A_CNT, v); chk("R3", v, 2, "decrement at P+1 cycles");
    edges(7);
    rd(A_CNT, v); chk("R3", v, 1, "count one cycle before expiry, P=3");
    rd(A_STA, v); chk("R4", v, 0, "flag before expiry, P=3");
    edges(1);
    rd(A_STA, v); chk("R4", v, 1, "flag at expiry, P=3");
    wr(A_STA, 32'h1);
  endtask

  task automatic t_autoreload_and_race;
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    wr(A_RLD, 32'd4);
    wr(A_CTL, 32'h0000_0003);
    edges(4);
    rd(A_CNT, v); chk("R5", v, 4, "count refilled at expiry");
    rd(A_STA, v); chk("R5", v, 1, "flag at auto expiry");
    edges(1);
    rd(A_CNT, v); chk("R5", v, 3, "counting continues after refill");
    wr(A_STA, 32'h1);
    rd(A_STA, v); chk("R11", v, 0, "clear between expiries");
    rd(A_CNT, v); chk("R5", v, 2, "count two before next expiry");
    edges(2);
    rd(A_STA, v); chk("R5", v, 1, "second auto expiry");
    rd(A_CNT, v); chk("R5", v, 4, "second refill");
    edges(3);
    wr(A_STA, 32'h1);
    rd(A_STA, v); chk("R12", v, 1, "expiry wins over same-cycle clear");
    wr(A_STA, 32'h1);
    rd(A_STA, v); chk("R12", v, 0, "later clear works");
  endtask

  task automatic t_hold;
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    wr(A_STA, 32'h1);
    wr(A_CNT, 32'd10);
    wr(A_CTL, 32'h0000_0001);
    edges(3);
    rd(A_CNT, v); chk("R3", v, 7, "running count before disable");
    wr(A_CTL, 32'h0);
    rd(A_CNT, v); chk("R10", v, 0, "disabled count reads zero");
    edges(5);
    wr(A_CTL, 32'h0000_0001);
    rd(A_CNT, v); chk("R3", v, 6, "count held while disabled");
    edges(1);
    rd(A_CNT, v); chk("R3", v, 5, "count resumes after enable");
  endtask

  task automatic t_zero;
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    wr(A_STA, 32'h1);
    wr(A_RLD, 32'd0);
    wr(A_CTL, 32'h0000_0003);
    edges(20);
    rd(A_CNT, v); chk("R8", v, 0, "zero count stays zero");
    rd(A_STA, v); chk("R8", v, 0, "zero count never flags");
    chk("R8", {31'b0, irq}, 0, "zero count never raises irq");
  endtask

  task automatic t_fill;
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    wr(A_RLD, 32'd7);
    wr(A_CNT, 32'd0);
    rd(A_RLD, v); chk("R7", v, 7, "count write keeps reload");
    wr(A_CTL, 32'h0000_0003);
    rd(A_CNT, v); chk("R9", v, 7, "enable with auto fills from reload");
    edges(1);
    rd(A_CNT, v); chk("R9", v, 6, "filled count runs");
    wr(A_CTL, 32'h0);
    wr(A_CNT, 32'd0);
    wr(A_CTL, 32'h0000_0001);
    edges(3);
    rd(A_CNT, v); chk("R9", v, 0, "enable without auto leaves zero");
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(A_CTL, 32'h0);
    wr(A_STA, 32'h1);
    wr(A_CTL, 32'h0000_0201);
    wr(A_CNT, 32'd9);
    edges(2);
    rd(A_CNT, v); chk("R7", v, 9, "count write while enabled");
    wr(A_CNT, 32'd4);
    rd(A_CNT, v); chk("R7", v, 4, "write overrides pending decrement");
    edges(2);
    rd(A_CNT, v); chk("R7", v, 4, "fresh prescaler phase after write");
    edges(1);
    rd(A_CNT, v); chk("R7", v, 3, "decrement P+1 after write");
    wr(A_RLD, 32'd8);
    rd(A_CNT, v); chk("R7", v, 8, "reload write restarts count");
    rd(A_RLD, v); chk("R7", v, 8, "reload value updated");
    edges(3);
    rd(A_CNT, v); chk("R7", v, 7, "decrement P+1 after reload write");
  endtask

  initial begin
    sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edges(4);
    t_reset();
    t_regmap();
    t_oneshot();
    t_prescale();
    t_autoreload_and_race();
    t_hold();
    t_zero();
    t_fill();
    t_restart();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule